// File: doc/BRIEF.md
# Privilege-Gated Control Register

This block holds a 64-bit configuration register for a processor core. The register carries three live fields: a coherency-participation enable, a retention delay code for the core, and a retention delay code for the vector/floating-point unit. The upper 57 bits are reserved. Software reaches the register through a single-register access port with a select, a write strobe and 64-bit write data. A read returns the value in the same cycle.

Whether an access may proceed depends on the current privilege level (0 to 3), the security state, and two delegation bits. One delegation bit comes from the level-3 control register and one from the level-2 control register. Level 0 may neither read nor write. Level 3 may always write. Write rights at levels 1 and 2 depend on the delegation bits and the security state. A refused access leaves the register untouched and raises a one-cycle fault pulse, which the surrounding logic turns into an exception.

A build parameter states whether the vector/floating-point unit exists. Without it, that unit's retention field reads as zero and ignores writes. The reset input is asserted asynchronously and released synchronously to the clock inside the block.

Top module: `priv_ctrl_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted write, `ctl_value` is zero and `coh_en`, `simd_ret`, `core_ret` and `acc_fault` are all zero.
- R2: Bits 63:7 of `ctl_value` and of `acc_rdata` always read as zero. Writes to those bits have no effect.
- R3: After an accepted write at clock edge E, from edge E onward `ctl_value[6:0]` holds the written bits. At that same point `coh_en` equals bit 6, `simd_ret` equals bits 5:3 and `core_ret` equals bits 2:0.
- R4: An access at level 0 (`cur_lvl` = 0) never changes the register. A level-0 read returns zero on `acc_rdata`. Any selected level-0 access raises `acc_fault` for the cycle after the request edge.
- R5: A write at level 1 is accepted only when `dlg_top`=1 and either `dlg_mid`=1 or `nonsecure`=0.
- R6: A write at level 2 is accepted only when `dlg_top`=1.
- R7: A write at level 3 is always accepted. A read (`acc_sel`=1, `acc_wr`=0) at levels 1 to 3 returns `ctl_value` on `acc_rdata` in the same cycle and raises no fault.
- R8: A refused write leaves `ctl_value` unchanged and sets `acc_fault` for exactly the one cycle after the request edge. While `acc_sel` is 0, `acc_fault` is 0 in the following cycle.
- R9: With `HAS_SIMD`=0, bits 5:3 and `simd_ret` always read as zero and ignore writes. With `HAS_SIMD`=1 they are stored.
- R10: The register can be rewritten any number of times after reset. Each accepted write replaces the whole 7-bit live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| nonsecure | input | 1 | 1 = non-secure state |
| dlg_top | input | 1 | Delegation bit from the level-3 control register |
| dlg_mid | input | 1 | Delegation bit from the level-2 control register |
| acc_sel | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, combinational, zero when no permitted read |
| ctl_value | output | 64 | Current register value |
| coh_en | output | 1 | Coherency participation enable (bit 6) |
| simd_ret | output | 3 | Vector/FP retention code (bits 5:3) |
| core_ret | output | 3 | Core retention code (bits 2:0) |
| acc_fault | output | 1 | One-cycle pulse after a refused access |

## Verification
The assertions assume that the access inputs are stable around each rising edge and free of X once reset is released. They also assume that an access lasts one cycle per request, so every fault pulse traces back to a single request edge. The stimulus changes all inputs only on falling edges. It presents each access for exactly one cycle and follows it with an idle cycle, so each fault pulse and each field update is observed on its own. The sweep covers every combination of level, security state and both delegation bits. It runs on two builds, one with the vector/FP field and one without, which receive identical stimulus.

// File: rtl/priv_ctrl_pkg.sv
package priv_ctrl_pkg;
  localparam int REG_W   = 64;
  localparam int FIELD_W = 7;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  typedef struct packed {
    logic       coh_en;
    logic [2:0] simd_ret;
    logic [2:0] core_ret;
  } ctl_fields_t;
endpackage

// File: rtl/pcr_rst_sync.sv
module pcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pcr_perm_check.sv
module pcr_perm_check
  import priv_ctrl_pkg::*;
(
  input  logic [1:0] cur_lvl,
  input  logic       nonsecure,
  input  logic       dlg_top,
  input  logic       dlg_mid,
  input  logic       acc_sel,
  input  logic       acc_wr,
  output logic       wr_ok,
  output logic       rd_ok,
  output logic       refused
);
  lvl_e lvl;
  logic wr_allowed;
  logic rd_allowed;

  assign lvl = lvl_e'(cur_lvl);

  always_comb begin
    wr_allowed = 1'b0;
    rd_allowed = 1'b1;
    case (lvl)
      LVL_USER: begin
        wr_allowed = 1'b0;
        rd_allowed = 1'b0;
      end
      LVL_KERNEL: wr_allowed = dlg_top & (dlg_mid | ~nonsecure);
      LVL_HYP:    wr_allowed = dlg_top;
      LVL_MON:    wr_allowed = 1'b1;
      default:    wr_allowed = 1'b0;
    endcase
  end

  assign wr_ok   = acc_sel &  acc_wr & wr_allowed;
  assign rd_ok   = acc_sel & ~acc_wr & rd_allowed;
  assign refused = acc_sel & ((acc_wr & ~wr_allowed) | (~acc_wr & ~rd_allowed));
endmodule

// File: rtl/pcr_storage.sv
module pcr_storage
  import priv_ctrl_pkg::*;
#(
  parameter bit HAS_SIMD = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  ctl_fields_t wr_fields,
  output ctl_fields_t cur_fields
);
  logic       coh_q, coh_d;
  logic [2:0] core_q, core_d;

  always_comb begin
    coh_d  = coh_q;
    core_d = core_q;
    if (wr_en) begin
      coh_d  = wr_fields.coh_en;
      core_d = wr_fields.core_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coh_q  <= 1'b0;
      core_q <= 3'b000;
    end else if (wr_en) begin
      coh_q  <= coh_d;
      core_q <= core_d;
    end
  end

  assign cur_fields.coh_en   = coh_q;
  assign cur_fields.core_ret = core_q;

  generate
    if (HAS_SIMD) begin : g_simd
      logic [2:0] simd_q, simd_d;
      always_comb simd_d = wr_en ? wr_fields.simd_ret : simd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     simd_q <= 3'b000;
        else if (wr_en) simd_q <= simd_d;
      end
      assign cur_fields.simd_ret = simd_q;
    end else begin : g_no_simd
      logic unused_simd_wr;
      assign unused_simd_wr      = ^wr_fields.simd_ret;
      assign cur_fields.simd_ret = 3'b000;
    end
  endgenerate
endmodule

// File: rtl/priv_ctrl_reg.sv
module priv_ctrl_reg
  import priv_ctrl_pkg::*;
#(
  parameter bit HAS_SIMD = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cur_lvl,
  input  logic                nonsecure,
  input  logic                dlg_top,
  input  logic                dlg_mid,
  input  logic                acc_sel,
  input  logic                acc_wr,
  input  logic [REG_W-1:0]    acc_wdata,
  output logic [REG_W-1:0]    acc_rdata,
  output logic [REG_W-1:0]    ctl_value,
  output logic                coh_en,
  output logic [2:0]          simd_ret,
  output logic [2:0]          core_ret,
  output logic                acc_fault
);
  localparam logic [REG_W-1:0] LIVE_MASK = HAS_SIMD ? 64'h7F : 64'h47;

  logic        rst_sync_n;
  logic        wr_ok, rd_ok, refused;
  logic        fault_q, fault_d;
  ctl_fields_t wr_fields, cur_fields;
  logic        unused_wdata_hi;

  pcr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pcr_perm_check u_perm (
    .cur_lvl   (cur_lvl),
    .nonsecure (nonsecure),
    .dlg_top   (dlg_top),
    .dlg_mid   (dlg_mid),
    .acc_sel   (acc_sel),
    .acc_wr    (acc_wr),
    .wr_ok     (wr_ok),
    .rd_ok     (rd_ok),
    .refused   (refused)
  );

  assign wr_fields       = ctl_fields_t'(acc_wdata[FIELD_W-1:0]);
  assign unused_wdata_hi = ^acc_wdata[REG_W-1:FIELD_W];

  pcr_storage #(.HAS_SIMD(HAS_SIMD)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_ok),
    .wr_fields  (wr_fields),
    .cur_fields (cur_fields)
  );

  always_comb fault_d = refused;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fault_q <= 1'b0;
    else             fault_q <= fault_d;
  end

  assign ctl_value = {{(REG_W-FIELD_W){1'b0}}, cur_fields};
  assign acc_rdata = rd_ok ? ctl_value : '0;
  assign coh_en    = cur_fields.coh_en;
  assign simd_ret  = cur_fields.simd_ret;
  assign core_ret  = cur_fields.core_ret;
  assign acc_fault = fault_q;

  // R7
  mon_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_sel && acc_wr && cur_lvl == 2'd3) |=> (ctl_value == ($past(acc_wdata) & LIVE_MASK)));

  // R6
  hyp_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_sel && acc_wr && cur_lvl == 2'd2 && dlg_top) |=> (ctl_value == ($past(acc_wdata) & LIVE_MASK)));

  // R8
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_sel && acc_wr && !wr_ok) |=> ($stable(ctl_value) && acc_fault));

  // R4
  user_fault_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_sel && cur_lvl == 2'd0) |=> acc_fault);

  // R4
  user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_sel && !acc_wr && cur_lvl == 2'd0) |-> (acc_rdata == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_sel |=> !acc_fault);

  // R3
  field_track_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ok |=> (coh_en == $past(acc_wdata[6]) && core_ret == $past(acc_wdata[2:0])));

  generate
    if (!HAS_SIMD) begin : g_chk_no_simd
      // R9
      simd_absent_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        wr_ok |=> (simd_ret == 3'b000));
    end
  endgenerate
endmodule

// File: tb/priv_ctrl_reg_bench.sv
`timescale 1ns/1ps
module priv_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cur_lvl;
  logic        nonsecure, dlg_top, dlg_mid, acc_sel, acc_wr;
  logic [63:0] acc_wdata;
  logic [63:0] rdata_a, value_a, rdata_b, value_b;
  logic        coh_a, coh_b, fault_a, fault_b;
  logic [2:0]  simd_a, simd_b, core_a, core_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  priv_ctrl_reg #(.HAS_SIMD(1'b1)) u_priv_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .nonsecure(nonsecure),
    .dlg_top(dlg_top), .dlg_mid(dlg_mid), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(rdata_a), .ctl_value(value_a),
    .coh_en(coh_a), .simd_ret(simd_a), .core_ret(core_a), .acc_fault(fault_a));

  priv_ctrl_reg #(.HAS_SIMD(1'b0)) u_priv_ctrl_reg_nosimd (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .nonsecure(nonsecure),
    .dlg_top(dlg_top), .dlg_mid(dlg_mid), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(rdata_b), .ctl_value(value_b),
    .coh_en(coh_b), .simd_ret(simd_b), .core_ret(core_b), .acc_fault(fault_b));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] rd_cap_a, rd_cap_b;

  task automatic access(input logic [1:0] lv, input logic ns, input logic d3, input logic d2,
                        input logic wr, input logic [63:0] data);
    @(negedge clk);
    cur_lvl = lv; nonsecure = ns; dlg_top = d3; dlg_mid = d2;
    acc_sel = 1'b1; acc_wr = wr; acc_wdata = data;
    #1;
    rd_cap_a = rdata_a;
    rd_cap_b = rdata_b;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0; acc_wdata = ~data;
    #1;
  endtask

  task automatic idle_check;
    @(negedge clk); #1;
    check("R8 quiet A", {63'd0, fault_a}, 64'd0);
    check("R8 quiet B", {63'd0, fault_b}, 64'd0);
  endtask

  function automatic bit may_write(input logic [1:0] lv, input logic ns, input logic d3, input logic d2);
    case (lv)
      2'd3:    return 1'b1;
      2'd2:    return d3;
      2'd1:    return d3 && (d2 || !ns);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] base, trial, exp_a, exp_b;
    bit ok;
    rst_n = 1'b0; cur_lvl = 2'd0; nonsecure = 1'b0; dlg_top = 1'b0; dlg_mid = 1'b0;
    acc_sel = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 value A in reset", value_a, 64'd0);
    check("R1 value B in reset", value_b, 64'd0);
    check("R1 fields A", {56'd0, coh_a, simd_a, core_a, fault_a}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 value A after release", value_a, 64'd0);
    check("R1 fault after release", {62'd0, fault_a, fault_b}, 64'd0);

    // Full sweep of level, security state and both delegation bits
    for (int i = 0; i < 32; i++) begin
      logic [1:0] lv = i[4:3];
      logic ns = i[2];
      logic d3 = i[1];
      logic d2 = i[0];
      base  = 64'hA5A5_0F0F_3C3C_0000 ^ (64'(i) * 64'h0101_0101_0101_0123);
      trial = ~base ^ {57'h1_2345_6789_ABCD, 7'(i * 37)};
      access(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, base);
      check("R7 level-3 write A", value_a, base & 64'h7F);
      check("R9 level-3 write B", value_b, base & 64'h47);
      idle_check();
      ok = may_write(lv, ns, d3, d2);
      access(lv, ns, d3, d2, 1'b1, trial);
      exp_a = (ok ? trial : base) & 64'h7F;
      exp_b = (ok ? trial : base) & 64'h47;
      case (lv)
        2'd0: check("R4 level-0 write A", value_a, exp_a);
        2'd1: check("R5 level-1 write A", value_a, exp_a);
        2'd2: check("R6 level-2 write A", value_a, exp_a);
        default: check("R7 level-3 write A", value_a, exp_a);
      endcase
      check("R9 write B", value_b, exp_b);
      check("R2 reserved A", {value_a[63:7], 7'd0}, 64'd0);
      check("R3 fields A", {57'd0, coh_a, simd_a, core_a}, exp_a);
      check("R9 simd B", {61'd0, simd_b}, 64'd0);
      check("R8 write fault A", {63'd0, fault_a}, {63'd0, !ok});
      check("R8 write fault B", {63'd0, fault_b}, {63'd0, !ok});
      idle_check();
      access(lv, ns, d3, d2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      if (lv == 2'd0) begin
        check("R4 level-0 read A", rd_cap_a, 64'd0);
        check("R4 level-0 read fault", {62'd0, fault_a, fault_b}, 64'd3);
      end else begin
        check("R7 read A", rd_cap_a, exp_a);
        check("R7 read B", rd_cap_b, exp_b);
        check("R7 read no fault", {62'd0, fault_a, fault_b}, 64'd0);
      end
      check("R4 read leaves value", value_a, exp_a);
      idle_check();
    end

    // Back-to-back run-time rewrites
    access(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 all ones A", value_a, 64'h7F);
    check("R10 all ones B", value_b, 64'h47);
    check("R3 coh bit", {63'd0, coh_a}, 64'd1);
    access(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0015);
    check("R10 second write A", value_a, 64'h15);
    check("R3 split fields", {58'd0, simd_a, core_a}, {58'd0, 3'd2, 3'd5});
    access(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h8000_0000_0000_0040);
    check("R10 third write A", value_a, 64'h40);
    check("R9 third write B", value_b, 64'h40);
    check("R8 no fault on accepted", {63'd0, fault_a}, 64'd0);
    idle_check();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule